// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Block

This block is the register bank of a simple LCD controller. A bus master writes and reads 32-bit words through a word-indexed address with a write strobe. Reads are combinational. The bank holds six registers: control, three timing words, a status word and a sub-panel word. Their decoded fields go out as ports to the controller's fetch, palette and sequencing logic.

The neighbouring blocks send back single-cycle pulses when a frame completes, when the palette has been loaded, or when a synchronisation error occurs. The bank keeps each pulse as a sticky flag. It combines the flags with two interrupt-enable bits into one level interrupt line. A sync error raises that line whatever the enables are. The bank also emits a one-cycle pulse whenever a write flips the enable bit, so that the frame sequencer can start or stop.

Top module: `lcd_regbank`

## Requirements
- R1: After reset, the register reads are: index 0 gives 0xFE000C34, index 1 gives 0x0000000F, indices 2, 4 and 5 give 0, and index 3 gives 0xFC000000. After reset, irq and en_change are 0.
- R2: The control register sits at word index 0.
  - Bit 0 is enable, bit 1 is mono, bits 4:3 are the interrupt enables, bit 7 is TFT and bits 21:20 are the palette-load mode.
  - The other written bits are kept under mask 0x01CFF300.
  - A read returns the stored fields ORed with 0xFE000C34, with the TFT bit also copied to bit 23.
- R3: Timing0 sits at word index 1 and timing1 at word index 2. Each keeps bits 9:0 as width-1 or height-1 and bits 31:10 as an opaque field. Both read back unchanged, except that timing0 also reads with bits 3:0 forced to one. width_m1 and height_m1 change only on writes to their own registers.
- R4: Timing2 sits at word index 3. It stores the full word and reads back ORed with 0xFC000000. The sub-panel register sits at word index 5 and stores the written word ANDed with 0xA1FFFFFF.
- R5: Status sits at word index 4 and reads palette-done at bit 6, sync-error at bit 2 and frame-done at bit 0. Writes to it change nothing.
- R6: Word indices 6 and above read as zero and ignore writes.
- R7: A pulse on frame_done_set, palette_done_set or sync_err_set sets the matching status flag on the next clock. The flag then stays set.
- R8: irq is high exactly when one of these holds:
  - frame-done and interrupt-enable bit 3 are both set;
  - palette-done and interrupt-enable bit 4 are both set;
  - sync-error is set, whatever the enables are.
- R9: A control write that clears a set enable has these effects:
  - It clears sync-error, even against a sync pulse in the same cycle.
  - It sets frame-done unless the written palette-load mode is 1.
- R10: A control write that sets a clear enable clears frame-done and palette-done, even against pulses in the same cycle.
- R11: en_change is high for exactly the one cycle after a write that flips enable. A write that leaves enable unchanged gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| frame_done_set | input | 1 | Frame completed pulse |
| palette_done_set | input | 1 | Palette loaded pulse |
| sync_err_set | input | 1 | Sync error pulse |
| irq | output | 1 | Level interrupt |
| en_change | output | 1 | One-cycle enable-flip pulse |
| enable | output | 1 | Controller enable |
| mono | output | 1 | Monochrome mode |
| tft | output | 1 | TFT mode |
| plm | output | 2 | Palette-load mode |
| irq_en | output | 2 | Interrupt enables |
| width_m1 | output | 10 | Width minus one |
| height_m1 | output | 10 | Height minus one |
| timing0_hi | output | 22 | Timing0 opaque field |
| timing1_hi | output | 22 | Timing1 opaque field |
| timing2 | output | 32 | Timing2 word |
| subpanel | output | 32 | Sub-panel word |
| ctrl_misc | output | 32 | Remaining masked control bits |

## Verification
The hardest cases to reach are the collisions between a control write that flips enable and a flag pulse in the same cycle. In these cases the write's clear must win over the pulse, and the frame-done set on disable depends on the palette-load mode carried in that same write word. The stimulus first enables the block and raises the flags one by one. It then drives the disabling write and a sync pulse on the same negative edge, and repeats the disable with mode 1 to show that frame-done is held back.

// File: rtl/lcd_regbank.sv
module lcd_regbank #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              frame_done_set,
  input  logic              palette_done_set,
  input  logic              sync_err_set,
  output logic              irq,
  output logic              en_change,
  output logic              enable,
  output logic              mono,
  output logic              tft,
  output logic [1:0]        plm,
  output logic [1:0]        irq_en,
  output logic [9:0]        width_m1,
  output logic [9:0]        height_m1,
  output logic [21:0]       timing0_hi,
  output logic [21:0]       timing1_hi,
  output logic [31:0]       timing2,
  output logic [31:0]       subpanel,
  output logic [31:0]       ctrl_misc
);
  localparam logic [ADDR_W-1:0] IX_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IX_T0   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IX_T1   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] IX_T2   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] IX_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] IX_SUB  = ADDR_W'(5);
  localparam logic [31:0] MISC_MASK = 32'h01CF_F300;
  localparam logic [31:0] CTRL_ONES = 32'hFE00_0C34;
  localparam logic [31:0] T2_ONES   = 32'hFC00_0000;
  localparam logic [31:0] SUB_MASK  = 32'hA1FF_FFFF;

  logic fd, pd, se;
  logic wr_ctrl, turn_on, turn_off;

  assign wr_ctrl  = wr_en && (addr == IX_CTRL);
  assign turn_on  = wr_ctrl && wdata[0] && !enable;
  assign turn_off = wr_ctrl && !wdata[0] && enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable     <= 1'b0;
      mono       <= 1'b0;
      tft        <= 1'b0;
      plm        <= 2'd0;
      irq_en     <= 2'd0;
      ctrl_misc  <= '0;
      width_m1   <= '0;
      height_m1  <= '0;
      timing0_hi <= '0;
      timing1_hi <= '0;
      timing2    <= '0;
      subpanel   <= '0;
      en_change  <= 1'b0;
    end else begin
      en_change <= turn_on || turn_off;
      if (wr_ctrl) begin
        enable    <= wdata[0];
        mono      <= wdata[1];
        irq_en    <= wdata[4:3];
        tft       <= wdata[7];
        plm       <= wdata[21:20];
        ctrl_misc <= wdata & MISC_MASK;
      end
      if (wr_en && addr == IX_T0) begin
        width_m1   <= wdata[9:0];
        timing0_hi <= wdata[31:10];
      end
      if (wr_en && addr == IX_T1) begin
        height_m1  <= wdata[9:0];
        timing1_hi <= wdata[31:10];
      end
      if (wr_en && addr == IX_T2)  timing2  <= wdata;
      if (wr_en && addr == IX_SUB) subpanel <= wdata & SUB_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fd <= 1'b0;
      pd <= 1'b0;
      se <= 1'b0;
    end else if (turn_on) begin
      fd <= 1'b0;
      pd <= 1'b0;
      se <= se | sync_err_set;
    end else if (turn_off) begin
      fd <= fd | frame_done_set | (wdata[21:20] != 2'd1);
      pd <= pd | palette_done_set;
      se <= 1'b0;
    end else begin
      fd <= fd | frame_done_set;
      pd <= pd | palette_done_set;
      se <= se | sync_err_set;
    end
  end

  assign irq = (fd & irq_en[0]) | (pd & irq_en[1]) | se;

  always_comb begin
    case (addr)
      IX_CTRL: rdata = CTRL_ONES | ctrl_misc | {8'd0, tft, 1'b0, plm, 12'd0, tft, 2'd0, irq_en, 1'b0, mono, enable};
      IX_T0:   rdata = {timing0_hi, width_m1} | 32'h0000_000F;
      IX_T1:   rdata = {timing1_hi, height_m1};
      IX_T2:   rdata = timing2 | T2_ONES;
      IX_STAT: rdata = {25'd0, pd, 3'd0, se, 1'b0, fd};
      IX_SUB:  rdata = subpanel;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/lcd_regbank_chk.sv
module lcd_regbank_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              sync_err_set,
  input logic              irq,
  input logic              en_change,
  input logic              enable,
  input logic [9:0]        width_m1,
  input logic              se
);
  p_sync_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err_set && !(wr_en && addr == ADDR_W'(0))) |=> irq);

  p_pulse_has_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    en_change |-> (enable != $past(enable)));

  p_flip_gives_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable != $past(enable)) |-> en_change);

  p_width_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_W'(1)) |=> $stable(width_m1));

  p_off_clears_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(0) && enable && !wdata[0]) |=> !se);
endmodule

bind lcd_regbank lcd_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .sync_err_set(sync_err_set), .irq(irq), .en_change(en_change),
  .enable(enable), .width_m1(width_m1), .se(se)
);

// File: tb/tb_lcd_regbank.sv
`timescale 1ns/1ps
module tb_lcd_regbank;
  localparam int AW = 6;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic fds = 1'b0, pds = 1'b0, ses = 1'b0;
  logic irq, en_change, enable, mono, tft;
  logic [1:0] plm, irq_en;
  logic [9:0] width_m1, height_m1;
  logic [21:0] t0h, t1h;
  logic [31:0] timing2, subpanel, ctrl_misc;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  lcd_regbank #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .frame_done_set(fds), .palette_done_set(pds), .sync_err_set(ses),
    .irq(irq), .en_change(en_change), .enable(enable), .mono(mono), .tft(tft),
    .plm(plm), .irq_en(irq_en), .width_m1(width_m1), .height_m1(height_m1),
    .timing0_hi(t0h), .timing1_hi(t1h), .timing2(timing2), .subpanel(subpanel),
    .ctrl_misc(ctrl_misc)
  );

  // {index, write word, expected readback}
  localparam logic [69:0] VEC [13] = '{
    {6'd0,  32'hFFFF_FFFE, 32'hFFFF_FFBE},  // R2
    {6'd0,  32'h0010_0080, 32'hFE90_0CB4},  // R2 mirror
    {6'd0,  32'h0000_0000, 32'hFE00_0C34},  // R2
    {6'd1,  32'h1234_5678, 32'h1234_567F},  // R3
    {6'd1,  32'h0000_0000, 32'h0000_000F},  // R3
    {6'd2,  32'hABCD_EF01, 32'hABCD_EF01},  // R3
    {6'd3,  32'h0000_1234, 32'hFC00_1234},  // R4
    {6'd3,  32'hFFFF_FFFF, 32'hFFFF_FFFF},  // R4
    {6'd4,  32'hFFFF_FFFF, 32'h0000_0000},  // R5
    {6'd5,  32'hFFFF_FFFF, 32'hA1FF_FFFF},  // R4
    {6'd5,  32'h5E00_0001, 32'h0000_0001},  // R4
    {6'd6,  32'hFFFF_FFFF, 32'h0000_0000},  // R6
    {6'd63, 32'hFFFF_FFFF, 32'h0000_0000}   // R6
  };

  function automatic string tag_of(logic [5:0] a);
    case (a)
      6'd0: return "R2";
      6'd1, 6'd2: return "R3";
      6'd3, 6'd5: return "R4";
      6'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(logic f, logic p, logic s);
    @(negedge clk);
    fds = f; pds = p; ses = s;
    @(negedge clk);
    fds = 1'b0; pds = 1'b0; ses = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 32'hFE00_0C34);
    rd(1, v); chk("R1 t0", v, 32'h0000_000F);
    rd(2, v); chk("R1 t1", v, 32'h0);
    rd(3, v); chk("R1 t2", v, 32'hFC00_0000);
    rd(4, v); chk("R1 status", v, 32'h0);
    rd(5, v); chk("R1 sub", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    chk("R1 en_change", {31'd0, en_change}, 32'h0);

    for (int i = 0; i < 13; i++) begin
      wr(VEC[i][69:64], VEC[i][63:32]);
      rd(VEC[i][69:64], v);
      chk(tag_of(VEC[i][69:64]), v, VEC[i][31:0]);
    end

    // R3 field outputs and minus-one storage
    wr(1, 32'h0000_03FF);
    chk("R3 width_m1", {22'd0, width_m1}, 32'h3FF);
    wr(2, 32'h0000_0400);
    chk("R3 height_m1", {22'd0, height_m1}, 32'h0);
    chk("R3 width hold", {22'd0, width_m1}, 32'h3FF);

    // R11 enable flip pulse
    wr(0, 32'h1);
    chk("R11 pulse", {31'd0, en_change}, 32'h1);
    @(negedge clk);
    chk("R11 one cycle", {31'd0, en_change}, 32'h0);
    wr(0, 32'h1);
    chk("R11 no flip", {31'd0, en_change}, 32'h0);

    // R7 R8 flags and interrupt masking
    pulse(1'b1, 1'b0, 1'b0);
    rd(4, v); chk("R7 frame", v, 32'h1);
    chk("R8 masked", {31'd0, irq}, 32'h0);
    wr(0, 32'h9);
    chk("R8 frame irq", {31'd0, irq}, 32'h1);
    pulse(1'b0, 1'b1, 1'b0);
    rd(4, v); chk("R7 palette", v, 32'h41);
    wr(0, 32'h11);
    chk("R8 palette irq", {31'd0, irq}, 32'h1);
    wr(0, 32'h1);
    chk("R8 none", {31'd0, irq}, 32'h0);
    pulse(1'b0, 1'b0, 1'b1);
    rd(4, v); chk("R7 sync", v, 32'h45);
    chk("R8 sync unmasked", {31'd0, irq}, 32'h1);

    // R9 disable clears sync, sets frame, wins over same-cycle sync pulse
    @(negedge clk);
    wr_en = 1'b1; addr = 0; wdata = 32'h0; ses = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ses = 1'b0;
    rd(4, v); chk("R9 off", v, 32'h41);
    chk("R9 irq low", {31'd0, irq}, 32'h0);
    chk("R11 off pulse", {31'd0, en_change}, 32'h1);

    // R10 enable clears done flags over same-cycle pulses
    @(negedge clk);
    wr_en = 1'b1; addr = 0; wdata = 32'h1; fds = 1'b1; pds = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; fds = 1'b0; pds = 1'b0;
    rd(4, v); chk("R10 on", v, 32'h0);

    // R9 mode 1 holds frame-done back
    wr(0, 32'h0010_0000);
    rd(4, v); chk("R9 mode1", v, 32'h0);
    wr(0, 32'h1);
    wr(0, 32'h0020_0000);
    rd(4, v); chk("R9 mode2", v, 32'h1);

    // R5 status write has no effect on flags
    wr(4, 32'h0);
    rd(4, v); chk("R5 ignore", v, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule